// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block passes data between two parallel ports, A and B, and controls each direction on its own. Each direction has one storage stage. When its latch-enable is high, the stage is transparent and the destination output follows the source input in the same cycle. When the latch-enable is low, the stage keeps its value. It loads a new value only when its transfer clock input rises. That transfer clock is an ordinary data input, sampled on the system clock. A rise is detected as high in the current cycle after low in the previous one.

Each direction has its own output enable, and the two enables have opposite polarity. The A-to-B enable is active high. The B-to-A enable is active low. The block does not drive pins itself. It presents a data-out value and a drive-enable for each port, which pad logic turns into three-state pins.

Each input port has a per-bit "driven" mask. An undriven bit is replaced by the last value that bit had while it was driven. This models a bus keeper. If both drive-enables are active together, a contention output is raised.

Top module: `bus_xcvr`

## Requirements
- R1: While le_ab is 1, b_out equals the bus-held A value in the same cycle, with no clock delay. The same holds for le_ba and a_out.
- R2: When le_ab goes from 1 to 0, b_out keeps the A value that was present in the last system-clock cycle before the fall.
- R3: While le_ab is 0 and clk_ab shows no rising edge, b_out keeps its value for any change on a_in.
- R4: While le_ab is 0, a rising clk_ab loads the current A value on that system-clock edge. A rising clk_ab means 1 in this cycle and 0 in the previous one. The new value appears on b_out after that edge.
- R5: A rising clk_ab while le_ab is 1 has no separate effect: b_out keeps following a_in.
- R6: b_oe is 1 exactly when oe_ab is 1 (active high).
- R7: The B-to-A direction uses le_ba, clk_ba and oe_ba_n with the behaviour of R1 to R4. a_oe is 1 exactly when oe_ba_n is 0 (active low).
- R8: contention is 1 exactly when a_oe and b_oe are both 1.
- R9: An input bit whose drv bit is 0 takes the value that bit last had on a system-clock edge while its drv bit was 1.
- R10: After reset, both storage stages and both keeper registers hold 0, and no rising transfer edge is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_in | input | W | A port input data |
| a_drv | input | W | Per-bit driven mask for a_in |
| b_in | input | W | B port input data |
| b_drv | input | W | Per-bit driven mask for b_in |
| le_ab | input | 1 | A-to-B latch enable, transparent when 1 |
| le_ba | input | 1 | B-to-A latch enable, transparent when 1 |
| clk_ab | input | 1 | A-to-B transfer clock, rising edge loads |
| clk_ba | input | 1 | B-to-A transfer clock, rising edge loads |
| oe_ab | input | 1 | B port drive enable, active high |
| oe_ba_n | input | 1 | A port drive enable, active low |
| a_out | output | W | Data to drive onto the A port |
| a_oe | output | 1 | A port drive enable |
| b_out | output | W | Data to drive onto the B port |
| b_oe | output | 1 | B port drive enable |
| contention | output | 1 | Both ports are driven at once |

## Verification
The bench builds the block with its default width of 18 bits. At this width, the test patterns can use alternating, walking and all-ones values that set the top bit and the bottom bit independently. This shows that the keeper mask and the storage stage work on each bit and not on the whole word. A mixed keeper mask, with half the bits driven and half held, checks the per-bit merge within a single word.

// File: rtl/bus_xcvr.sv
module bus_xcvr #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] a_drv,
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] b_drv,
  input  logic         le_ab,
  input  logic         le_ba,
  input  logic         clk_ab,
  input  logic         clk_ba,
  input  logic         oe_ab,
  input  logic         oe_ba_n,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic [W-1:0] b_out,
  output logic         b_oe,
  output logic         contention
);

  logic [W-1:0] keep_a, keep_b;
  logic [W-1:0] a_eff, b_eff;
  logic [W-1:0] q_ab, q_ba;
  logic         clk_ab_d, clk_ba_d;
  logic         up;

  // bus keeper: undriven bits take their last driven value
  assign a_eff = (a_in & a_drv) | (keep_a & ~a_drv);
  assign b_eff = (b_in & b_drv) | (keep_b & ~b_drv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      keep_a <= '0;
      keep_b <= '0;
    end else begin
      keep_a <= a_eff;
      keep_b <= b_eff;
    end
  end

  wire ab_rise = clk_ab & ~clk_ab_d;
  wire ba_rise = clk_ba & ~clk_ba_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_ab     <= '0;
      q_ba     <= '0;
      clk_ab_d <= 1'b0;
      clk_ba_d <= 1'b0;
      up       <= 1'b0;
    end else begin
      clk_ab_d <= clk_ab;
      clk_ba_d <= clk_ba;
      up       <= 1'b1;
      if (le_ab || ab_rise) q_ab <= a_eff;
      if (le_ba || ba_rise) q_ba <= b_eff;
    end
  end

  assign b_out      = le_ab ? a_eff : q_ab;
  assign a_out      = le_ba ? b_eff : q_ba;
  assign b_oe       = oe_ab;
  assign a_oe       = ~oe_ba_n;
  assign contention = a_oe & b_oe;

  AST_AB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_ab && !(clk_ab && !clk_ab_d)) |=> (q_ab == $past(q_ab))); // R3
  AST_BA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_ba && !(clk_ba && !clk_ba_d)) |=> (q_ba == $past(q_ba))); // R7
  AST_AB_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (up && $fell(le_ab)) |-> (b_out == $past(a_eff))); // R2
  AST_BOTH_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_ab && !oe_ba_n) |-> contention); // R8
  AST_KEEP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (a_drv == '0) |=> (keep_a == $past(keep_a))); // R9

endmodule

// File: tb/tb_bus_xcvr.sv
module tb_bus_xcvr;
  localparam int W = 18;
  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] a_in, a_drv, b_in, b_drv;
  logic le_ab, le_ba, clk_ab, clk_ba, oe_ab, oe_ba_n;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe, contention;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bus_xcvr #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_drv(a_drv), .b_in(b_in), .b_drv(b_drv),
    .le_ab(le_ab), .le_ba(le_ba), .clk_ab(clk_ab), .clk_ba(clk_ba),
    .oe_ab(oe_ab), .oe_ba_n(oe_ba_n), .a_out(a_out), .a_oe(a_oe),
    .b_out(b_out), .b_oe(b_oe), .contention(contention));

  task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    rst_n = 0; a_in = '0; b_in = '0; a_drv = '1; b_drv = '1;
    le_ab = 0; le_ba = 0; clk_ab = 0; clk_ba = 0; oe_ab = 0; oe_ba_n = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    a_in = 18'h2AAAA; b_in = 18'h15555;
    #1;
    chk("R10 b_out", b_out, '0);
    chk("R10 a_out", a_out, '0);
    chk("R6 b_oe", {17'b0, b_oe}, 0);
    chk("R7 a_oe", {17'b0, a_oe}, 0);
  endtask

  task automatic t_transparent();
    @(negedge clk); le_ab = 1; a_in = 18'h3F00F; #1;
    chk("R1 same cycle", b_out, 18'h3F00F);
    @(negedge clk); a_in = 18'h00FF0; #1;
    chk("R1 follow", b_out, 18'h00FF0);
  endtask

  task automatic t_close_and_hold();
    @(negedge clk); a_in = 18'h12345;
    @(negedge clk); le_ab = 0; a_in = 18'h3FFFF; #1;
    chk("R2 close", b_out, 18'h12345);
    tick();
    chk("R2 after edge", b_out, 18'h12345);
    @(negedge clk); a_in = 18'h00001;
    tick(); tick();
    chk("R3 no clk", b_out, 18'h12345);
  endtask

  task automatic t_edge_load();
    @(negedge clk); a_in = 18'h20001; clk_ab = 1; #1;
    chk("R4 before edge", b_out, 18'h12345);
    tick();
    chk("R4 loaded", b_out, 18'h20001);
    @(negedge clk); a_in = 18'h0AAAA;
    tick();
    chk("R3 clk held high", b_out, 18'h20001);
    @(negedge clk); clk_ab = 0;
    tick();
    chk("R3 falling clk", b_out, 18'h20001);
  endtask

  task automatic t_edge_transparent();
    @(negedge clk); le_ab = 1; a_in = 18'h11111; clk_ab = 1;
    tick();
    chk("R5 rise while open", b_out, 18'h11111);
    @(negedge clk); a_in = 18'h22222; #1;
    chk("R5 still follows", b_out, 18'h22222);
    @(negedge clk); clk_ab = 0; le_ab = 0;
  endtask

  task automatic t_enables();
    @(negedge clk); oe_ab = 1; oe_ba_n = 1; #1;
    chk("R6 b_oe on", {17'b0, b_oe}, 1);
    chk("R8 one side", {17'b0, contention}, 0);
    @(negedge clk); oe_ab = 0; oe_ba_n = 0; #1;
    chk("R7 a_oe active low", {17'b0, a_oe}, 1);
    chk("R6 b_oe off", {17'b0, b_oe}, 0);
    @(negedge clk); oe_ab = 1; #1;
    chk("R8 both", {17'b0, contention}, 1);
    @(negedge clk); oe_ab = 0; oe_ba_n = 1;
  endtask

  task automatic t_ba_path();
    @(negedge clk); le_ba = 1; b_in = 18'h0F0F0; #1;
    chk("R7 transparent", a_out, 18'h0F0F0);
    @(negedge clk); le_ba = 0; b_in = 18'h3C3C3; #1;
    chk("R7 close", a_out, 18'h0F0F0);
    @(negedge clk); clk_ba = 1;
    tick();
    chk("R7 edge load", a_out, 18'h3C3C3);
    @(negedge clk); clk_ba = 0;
  endtask

  task automatic t_keeper();
    @(negedge clk); le_ab = 1; a_drv = '1; a_in = 18'h2D2D2;
    tick();
    @(negedge clk); a_drv = '0; a_in = 18'h00000; #1;
    chk("R9 all held", b_out, 18'h2D2D2);
    tick(); tick();
    chk("R9 held later", b_out, 18'h2D2D2);
    @(negedge clk); a_drv = 18'h001FF; a_in = 18'h3FFFF; #1;
    chk("R9 mixed mask", b_out, 18'h2D3FF);
    @(negedge clk); a_drv = '1; le_ab = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_transparent();
    t_close_and_hold();
    t_edge_load();
    t_edge_transparent();
    t_enables();
    t_ba_path();
    t_keeper();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule